// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block remembers where taken control transfers went, so that the fetch stage can redirect on the next encounter of the same instruction address. It is organised as a direct-mapped table. A fetch address selects one entry through its word-index bits. The remaining upper address bits are kept as a full tag beside a stored target. A lookup that matches a valid entry's tag reports a hit with that target. Any other lookup reports a miss, and fetch then continues sequentially.

Writes come from the resolution stage. An entry is written only when the update strobe is high and the transfer was actually taken. Jumps and taken conditional branches qualify; a conditional branch resolved as not taken does not. A write to an occupied slot replaces whatever was there. The read path is combinational from registered storage. A lookup therefore sees the table as it stood before any write landing at the same clock edge.

Top module: `btb_top`

## Requirements
- R1: A synchronous active-low reset invalidates every entry, so every lookup afterwards misses until a new write.
- R2: An entry is written at a rising clock edge only when `upd_en` and `upd_taken` are both 1; with `upd_en` at 0 nothing changes, whatever `upd_taken` is.
- R3: An update with `upd_en` 1 and `upd_taken` 0 (a not-taken conditional branch) allocates nothing, and a later lookup of that address misses.
- R4: The index is address bits [9:2] and the tag is bits [31:10] for 256 entries; bits [1:0] take no part, so addresses differing only there return the same result.
- R5: On a miss `lk_hit` is 0 and `lk_target` is all zeros; on a hit `lk_target` is the stored target.
- R6: A write to an index that already holds an entry overwrites its tag and target; the old address then misses and the new one hits with the new target.
- R7: A lookup in the same cycle as a write to the same index returns the contents from before the write; the new contents are visible from the cycle after the edge.
- R8: Two addresses with the same index but different tags never both hit; a lookup whose tag differs from the stored one misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_target | output | 32 | Predicted target on a hit, zero otherwise |
| upd_en | input | 1 | Update strobe from branch resolution |
| upd_pc | input | 32 | Address of the resolved transfer |
| upd_target | input | 32 | Resolved target address |
| upd_taken | input | 1 | Transfer was taken; write is allowed |

## Verification
A corrupted valid bit shows as a spurious hit or a lost hit on the very next lookup of that index, since the read path is combinational. A bad tag compare shows as aliasing between addresses that share an index, which the bench provokes on purpose. A write that lands at the wrong edge shows in the same-cycle lookup, which must still return the old target and then the new one one cycle later.

// File: rtl/btb_pkg.sv
// Shared constants for the branch target buffer.
// Assumes word-aligned instructions: the two lowest address bits are never used.
package btb_pkg;
    localparam int unsigned BYTE_OFS_W = 2;
endpackage

// File: rtl/btb_addr_split.sv
// Splits an instruction address into table index and tag.
// Assumes IDX_W + BYTE_OFS_W < PC_W; the byte-offset bits are dropped.
module btb_addr_split
    import btb_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 8,
    localparam int unsigned TAG_W = PC_W - IDX_W - BYTE_OFS_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    logic unused_ofs;

    // Pick index above the byte offset and tag above the index.
    always_comb begin
        idx        = pc[BYTE_OFS_W +: IDX_W];
        tag        = pc[PC_W-1 -: TAG_W];
        unused_ofs = ^pc[BYTE_OFS_W-1:0];
    end
endmodule

// File: rtl/btb_store.sv
// Storage for valid bits, tags and targets, one write port and one read port.
// Assumes reads are combinational from registers, so a write is seen only
// after its clock edge. Only valid bits are reset.
module btb_store #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned TAG_W   = 22,
    parameter int unsigned TGT_W   = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    // Valid bits: cleared by reset, set by each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target payload: overwritten on each write, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // Combinational read of the addressed entry.
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
    end

    // After a reset cycle, no entry may be valid.
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (valid_q == '0));

    // Without a write, the valid bits hold.
    assert_no_write_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en) |=> $stable(valid_q));

    // A write leaves its entry valid with the written tag.
    assert_write_tag_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

    // A write leaves the written target in its entry.
    assert_write_tgt_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tgt_q[$past(wr_idx)] == $past(wr_tgt)));
endmodule

// File: rtl/btb_top.sv
// Direct-mapped branch target buffer. Lookup is combinational; updates are
// written on the clock edge only for taken transfers under the update strobe.
// Assumes a single lookup and a single update per cycle.
module btb_top
    import btb_pkg::*;
#(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned PC_W    = 32,
    parameter int unsigned TGT_W   = 32,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = PC_W - IDX_W - BYTE_OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic [TGT_W-1:0] lk_target,
    input  logic             upd_en,
    input  logic [PC_W-1:0]  upd_pc,
    input  logic [TGT_W-1:0] upd_target,
    input  logic             upd_taken
);
    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             wr_go;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [TGT_W-1:0] rd_tgt;

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) i_lk_split (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );

    btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W)) i_up_split (
        .pc(upd_pc), .idx(up_idx), .tag(up_tag)
    );

    // Write permission: strobe and taken outcome together.
    always_comb wr_go = upd_en && upd_taken;

    btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_go), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(upd_target),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt)
    );

    // Hit detection and target gating.
    always_comb begin
        lk_hit    = rd_valid && (rd_tag == lk_tag);
        lk_target = lk_hit ? rd_tgt : '0;
    end

    // A not-taken strobe must not make an absent address start hitting.
    assert_not_taken_no_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_taken && !lk_hit && lk_pc == upd_pc) |=>
            ($stable(lk_pc) |-> !lk_hit));
endmodule

// File: tb/test_btb_top.sv
module test_btb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_pc;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic        upd_en;
    logic [31:0] upd_pc;
    logic [31:0] upd_target;
    logic        upd_taken;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    btb_top i_btb_top (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_target(lk_target),
        .upd_en(upd_en), .upd_pc(upd_pc), .upd_target(upd_target),
        .upd_taken(upd_taken)
    );

    // Vector: {en, taken, wr_pc, wr_tgt, look_pc, exp_hit, exp_tgt}
    localparam int NV = 8;
    localparam logic [130:0] VEC [NV] = '{
        {1'b1, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'h0000_1000, 1'b1, 32'h0000_2000}, // R2 write/hit
        {1'b0, 1'b0, 32'h0,         32'h0,         32'h0000_1002, 1'b1, 32'h0000_2000}, // R4 low bits ignored
        {1'b1, 1'b0, 32'h0000_1004, 32'h0000_3000, 32'h0000_1004, 1'b0, 32'h0},         // R3 not taken
        {1'b0, 1'b1, 32'h0000_1008, 32'h0000_4000, 32'h0000_1008, 1'b0, 32'h0},         // R2 no strobe
        {1'b0, 1'b0, 32'h0,         32'h0,         32'h0000_1400, 1'b0, 32'h0},         // R8 alias misses
        {1'b1, 1'b1, 32'h0000_1400, 32'h0000_5000, 32'h0000_1000, 1'b0, 32'h0},         // R6 old evicted
        {1'b0, 1'b0, 32'h0,         32'h0,         32'h0000_1400, 1'b1, 32'h0000_5000}, // R6 new hits
        {1'b1, 1'b1, 32'h0000_03FC, 32'hDEAD_BEEC, 32'h0000_03FC, 1'b1, 32'hDEAD_BEEC}  // R4 top index
    };

    task automatic check(input string req, input logic eh, input logic [31:0] et);
        total++;
        if (lk_hit !== eh || lk_target !== et) begin
            bad++;
            $display("FAIL %s pc=%h actual hit=%b tgt=%h expected hit=%b tgt=%h",
                     req, lk_pc, lk_hit, lk_target, eh, et);
        end
    endtask

    initial begin
        #150000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_pc = '0; upd_en = 1'b0; upd_pc = '0;
        upd_target = '0; upd_taken = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2 check("R1", 1'b0, 32'h0);
        lk_pc = 32'h0000_03FC;
        #1 check("R5", 1'b0, 32'h0);

        // Table walk: one update cycle, then one lookup.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            upd_en     = VEC[i][130];
            upd_taken  = VEC[i][129];
            upd_pc     = VEC[i][128:97];
            upd_target = VEC[i][96:65];
            @(negedge clk);
            upd_en = 1'b0; upd_taken = 1'b0;
            lk_pc = VEC[i][64:33];
            #2 check($sformatf("vec%0d R2/R3/R4/R5/R6/R8", i), VEC[i][32], VEC[i][31:0]);
        end

        // R7: same-cycle lookup returns old contents, new one after the edge.
        @(negedge clk);
        lk_pc = 32'h0000_1401; upd_pc = 32'h0000_1400;
        upd_target = 32'h0000_6000; upd_en = 1'b1; upd_taken = 1'b1;
        #2 check("R7 before edge", 1'b1, 32'h0000_5000);
        @(negedge clk);
        upd_en = 1'b0; upd_taken = 1'b0;
        #2 check("R7 after edge", 1'b1, 32'h0000_6000);

        // R8: other tag at same index 255 misses while entry is valid.
        lk_pc = 32'h0001_03FC;
        #1 check("R8", 1'b0, 32'h0);

        // R1: reset again clears all entries.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        lk_pc = 32'h0000_1400;
        #2 check("R1 after reset idx0", 1'b0, 32'h0);
        lk_pc = 32'h0000_03FC;
        #1 check("R1 after reset idx255", 1'b0, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule